// File: doc/BRIEF.md
# Operand Bypass and Hazard Stall Controller

This block is the data-hazard decision logic of a five-stage in-order pipeline (fetch, decode, execute, memory access, write-back). It looks at the source register numbers of the instruction in decode and of the instruction in execute. It compares them with the destination registers of the older instructions still in flight. From this it produces two outputs: a source select for each ALU operand and a single stall decision. That decision freezes the program counter and the fetch/decode register and turns the next execute-stage entry into a bubble. Branch operands are resolved in the execute stage, so they follow the same rules.

The register file writes early in a cycle and reads late in it. An instruction three or more places behind its producer therefore reads the correct value directly. The static parameter `MODE` selects how many bypass paths exist: none, only from the execute/memory register, only from the memory/write-back register, or both. For each choice, the controller stalls exactly as long as the missing paths require and never longer.

The datapath multiplexers, the register file and the pipeline registers sit outside the block. The enclosing pipeline clears the control fields entering execute when `idex_bubble` is high.

Top module: `hzd_forward_unit`

## Requirements
- R1: Operand select codes are 2'b00 register file, 2'b10 the execute/memory register result, 2'b01 the memory/write-back register result. With MODE none, both selects are always 2'b00.
- R2: A source or destination register number of 0 never causes a stall and never selects a bypass.
- R3: No stall occurs unless a used decode-stage source matches a written, nonzero destination in the execute or memory-access stage. A consumer three or more instructions behind its producer takes no stall and selects the register file.
- R4: MODE none: a consumer one instruction behind an ALU result or load stalls 2 cycles; two behind, 1 cycle; then it reads the register file.
- R5: MODE execute/memory only: an ALU result one behind is bypassed with no stall via 2'b10. At distance two, an ALU result or load stalls 1 cycle. A load one behind stalls 2 cycles. Both stalled cases then read the register file.
- R6: MODE memory/write-back only: a consumer one behind an ALU result or load stalls 1 cycle and then selects 2'b01. At distance two it is bypassed with no stall via 2'b01.
- R7: MODE full: ALU results at distance one and two are bypassed with no stall via 2'b10 and 2'b01. A load one behind stalls exactly 1 cycle and then selects 2'b01.
- R8: When the execute/memory and memory/write-back entries both match an operand, the execute/memory (younger) entry wins. This gives 2'b10 in full mode.
- R9: `pc_hold`, `ifid_hold` and `idex_bubble` are always equal. A source whose use flag is low never causes a stall.
- R10: In every mode, a load directly followed by an instruction that uses its destination stalls the follower.
- R11: The two operands are judged independently. A stall is asked for if either one needs it, and each operand receives its own select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs1 | input | REG_W | First source register of the decode-stage instruction |
| id_rs2 | input | REG_W | Second source register of the decode-stage instruction |
| id_rs1_use | input | 1 | Decode-stage instruction reads its first source |
| id_rs2_use | input | 1 | Decode-stage instruction reads its second source |
| ex_rs1 | input | REG_W | First source register of the execute-stage instruction |
| ex_rs2 | input | REG_W | Second source register of the execute-stage instruction |
| ex_rd | input | REG_W | Destination of the execute-stage instruction |
| ex_reg_we | input | 1 | Execute-stage instruction writes a register |
| ex_mem_rd | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | REG_W | Destination held in the execute/memory register |
| mem_reg_we | input | 1 | Execute/memory entry writes a register |
| mem_mem_rd | input | 1 | Execute/memory entry is a load |
| wb_rd | input | REG_W | Destination held in the memory/write-back register |
| wb_reg_we | input | 1 | Memory/write-back entry writes a register |
| fwd_a | output | 2 | Source select for ALU operand A |
| fwd_b | output | 2 | Source select for ALU operand B |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_bubble | output | 1 | Clear the control fields entering execute |

## Verification
The bench builds four instances side by side, one for each `MODE` value, all with the default 5-bit register numbers. Each runs the same instruction stream through its own small pipeline model driven by the block's hold and bubble outputs. Every dependence class can therefore be seen under every bypass option in one run: ALU and load producers at distances one, two and three, register 0, a shadowed double producer, an unused source and a two-operand consumer. For each consumer, the measured stall length and the selects seen in the execute stage are compared with values derived from the requirements.

// File: rtl/hzd_pkg.sv
// Shared types for the hazard controller.
// Assumes: the mode is fixed at elaboration; select codes are decoded by
// the operand multiplexers outside this block.
package hzd_pkg;

    typedef enum logic [1:0] {
        FWD_NONE  = 2'd0,
        FWD_EXMEM = 2'd1,
        FWD_MEMWB = 2'd2,
        FWD_FULL  = 2'd3
    } fwd_mode_e;

    typedef enum logic [1:0] {
        SRC_RF    = 2'b00,
        SRC_MEMWB = 2'b01,
        SRC_EXMEM = 2'b10
    } opnd_src_e;

    // True when the execute/memory bypass path exists
    function automatic bit has_exmem(fwd_mode_e m);
        return (m == FWD_EXMEM) || (m == FWD_FULL);
    endfunction

    // True when the memory/write-back bypass path exists
    function automatic bit has_memwb(fwd_mode_e m);
        return (m == FWD_MEMWB) || (m == FWD_FULL);
    endfunction

    // Longest stall any single instruction can see in a mode
    function automatic int stall_limit(fwd_mode_e m);
        return ((m == FWD_NONE) || (m == FWD_EXMEM)) ? 2 : 1;
    endfunction

endpackage

// File: rtl/hzd_reg_cmp.sv
// Register-number match: a source depends on a destination when the
// destination is written and is not register 0.
// Assumes: register 0 is hard-wired and never carries a dependence.
module hzd_reg_cmp #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] dst,
    input  logic             dst_we,
    output logic             hit
);

    // Dependence exists only for a written, nonzero, equal register
    assign hit = dst_we && (dst != '0) && (src == dst);

endmodule

// File: rtl/hzd_stall_ctl.sv
// Stall decision for the decode-stage instruction. Each used source is
// compared with the execute-stage and memory-stage destinations, and the
// mode decides which matches can still be covered by a bypass later.
// Assumes: the write-back stage writes before decode reads in the same
// cycle, so write-back destinations never cause a stall.
module hzd_stall_ctl
    import hzd_pkg::*;
#(
    parameter int        REG_W = 5,
    parameter int        NSRC  = 2,
    parameter fwd_mode_e MODE  = FWD_FULL
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSRC-1:0][REG_W-1:0]  src,
    input  logic [NSRC-1:0]             src_use,
    input  logic [REG_W-1:0]            ex_rd,
    input  logic                        ex_we,
    input  logic                        ex_ld,
    input  logic [REG_W-1:0]            mem_rd,
    input  logic                        mem_we,
    output logic                        stall
);

    localparam int STALL_MAX = stall_limit(MODE);

    logic [NSRC-1:0] need;
    logic [NSRC-1:0] hit_ex;
    logic [NSRC-1:0] hit_mem;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        hzd_reg_cmp #(.REG_W(REG_W)) u_cmp_ex (
            .src(src[i]), .dst(ex_rd), .dst_we(ex_we), .hit(hit_ex[i])
        );
        hzd_reg_cmp #(.REG_W(REG_W)) u_cmp_mem (
            .src(src[i]), .dst(mem_rd), .dst_we(mem_we), .hit(hit_mem[i])
        );

        // Per-source stall rule for the configured bypass paths
        always_comb begin
            case (MODE)
                FWD_NONE:  need[i] = hit_ex[i] || hit_mem[i];
                // distance two has no path; a younger ALU match shadows it
                FWD_EXMEM: need[i] = (hit_ex[i] && ex_ld) || (hit_mem[i] && !hit_ex[i]);
                FWD_MEMWB: need[i] = hit_ex[i];
                default:   need[i] = hit_ex[i] && ex_ld;
            endcase
            need[i] = need[i] && src_use[i];
        end
    end

    assign stall = |need;

    // Length of the current stall run, used by the bound check below
    logic [1:0] run_q;

    // Count consecutive stall cycles; clear on any advancing cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (stall)
            run_q <= (run_q == 2'd3) ? run_q : run_q + 2'd1;
        else
            run_q <= '0;
    end

    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (int'(run_q) < STALL_MAX)); // R4

endmodule

// File: rtl/hzd_fwd_sel.sv
// Operand source select for one ALU input of the execute-stage instruction.
// The execute/memory entry is younger, so it is preferred over the
// memory/write-back entry when both name the same register.
// Assumes: the stall controller has already held back any consumer whose
// value cannot be supplied by the paths present in this mode.
module hzd_fwd_sel
    import hzd_pkg::*;
#(
    parameter int        REG_W = 5,
    parameter fwd_mode_e MODE  = FWD_FULL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_we,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_we,
    output opnd_src_e        sel
);

    localparam bit USE_EM = has_exmem(MODE);
    localparam bit USE_MW = has_memwb(MODE);

    logic hit_mem;
    logic hit_wb;

    hzd_reg_cmp #(.REG_W(REG_W)) u_cmp_mem (
        .src(src), .dst(mem_rd), .dst_we(mem_we), .hit(hit_mem)
    );
    hzd_reg_cmp #(.REG_W(REG_W)) u_cmp_wb (
        .src(src), .dst(wb_rd), .dst_we(wb_we), .hit(hit_wb)
    );

    // Pick the youngest available producer, else the register file
    always_comb begin
        if (USE_EM && hit_mem)
            sel = SRC_EXMEM;
        else if (USE_MW && hit_wb && !hit_mem)
            sel = SRC_MEMWB;
        else
            sel = SRC_RF;
    end

    AST_R0_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (src == '0) |-> (sel == SRC_RF)); // R2

endmodule

// File: rtl/hzd_forward_unit.sv
// Top of the hazard controller: operand selects for both ALU inputs of the
// execute stage and one stall decision for the decode stage.
// Assumes: the pipeline applies pc_hold, ifid_hold and idex_bubble in the
// same cycle, and clears the write and load flags of a bubble.
module hzd_forward_unit
    import hzd_pkg::*;
#(
    parameter int        REG_W = 5,
    parameter fwd_mode_e MODE  = FWD_FULL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic             id_rs1_use,
    input  logic             id_rs2_use,
    input  logic [REG_W-1:0] ex_rs1,
    input  logic [REG_W-1:0] ex_rs2,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_reg_we,
    input  logic             ex_mem_rd,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_reg_we,
    input  logic             mem_mem_rd,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_reg_we,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b,
    output logic             pc_hold,
    output logic             ifid_hold,
    output logic             idex_bubble
);

    localparam int  NSRC   = 2;
    localparam bit  HAS_EM = has_exmem(MODE);

    logic [NSRC-1:0][REG_W-1:0] id_src;
    logic [NSRC-1:0]            id_use;
    logic [NSRC-1:0][REG_W-1:0] ex_src;
    opnd_src_e                  sel [NSRC];
    logic                       stall;

    assign id_src = {id_rs2, id_rs1};
    assign id_use = {id_rs2_use, id_rs1_use};
    assign ex_src = {ex_rs2, ex_rs1};

    hzd_stall_ctl #(.REG_W(REG_W), .NSRC(NSRC), .MODE(MODE)) u_stall (
        .clk(clk), .rst_n(rst_n),
        .src(id_src), .src_use(id_use),
        .ex_rd(ex_rd), .ex_we(ex_reg_we), .ex_ld(ex_mem_rd),
        .mem_rd(mem_rd), .mem_we(mem_reg_we),
        .stall(stall)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_opnd
        hzd_fwd_sel #(.REG_W(REG_W), .MODE(MODE)) u_sel (
            .clk(clk), .rst_n(rst_n),
            .src(ex_src[i]),
            .mem_rd(mem_rd), .mem_we(mem_reg_we),
            .wb_rd(wb_rd), .wb_we(wb_reg_we),
            .sel(sel[i])
        );
    end

    assign fwd_a       = sel[0];
    assign fwd_b       = sel[1];
    assign pc_hold     = stall;
    assign ifid_hold   = stall;
    assign idex_bubble = stall;

    AST_NO_IDLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !((id_rs1_use && id_rs1 != '0 &&
           ((ex_reg_we && id_rs1 == ex_rd) || (mem_reg_we && id_rs1 == mem_rd))) ||
          (id_rs2_use && id_rs2 != '0 &&
           ((ex_reg_we && id_rs2 == ex_rd) || (mem_reg_we && id_rs2 == mem_rd))))
        |-> !pc_hold); // R3

    AST_LOAD_USE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_mem_rd && ex_reg_we && ex_rd != '0 &&
         ((id_rs1_use && id_rs1 == ex_rd) || (id_rs2_use && id_rs2 == ex_rd)))
        |-> pc_hold); // R10

    AST_YOUNGER_WINS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_EM && mem_reg_we && mem_rd != '0 && ex_rs1 == mem_rd)
        |-> (fwd_a == 2'b10)); // R8

    AST_YOUNGER_WINS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_EM && mem_reg_we && mem_rd != '0 && ex_rs2 == mem_rd)
        |-> (fwd_b == 2'b10)); // R8

    AST_NO_BYPASS_OF_PENDING_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ((fwd_a == 2'b10) || (fwd_b == 2'b10)) |-> !mem_mem_rd); // R7

endmodule

// File: tb/tb_hzd_forward_unit.sv
// Bench: four controllers, one per mode, each steering its own small
// pipeline model over one shared instruction stream. A driver pushes the
// expected stall length and selects of every consumer into a queue per
// mode; a monitor pops and compares when that consumer reaches execute.
module tb_hzd_forward_unit;
    import hzd_pkg::*;

    localparam int NSC  = 11;
    localparam int PLEN = 128;
    localparam logic [1:0] RF = 2'b00;
    localparam logic [1:0] EM = 2'b10;
    localparam logic [1:0] MW = 2'b01;

    typedef struct packed {
        logic [4:0] rs1;
        logic [4:0] rs2;
        logic [4:0] rd;
        logic       we;
        logic       ld;
        logic       u1;
        logic       u2;
        logic       cons;
    } slot_t;

    typedef struct {
        int         stalls;
        logic [1:0] a;
        logic [1:0] b;
        bit         chk_a;
        int         req;
    } exp_t;

    logic  clk = 1'b0;
    logic  rst_n = 1'b0;
    slot_t prog [PLEN];
    int    plen;

    always #5 clk = ~clk;

    // Expected outcome per mode and scenario, taken from the requirements.
    // Modes: 0 none (R4), 1 EX/MEM only (R5), 2 MEM/WB only (R6), 3 full (R7).
    // Select codes (R1): RF 00, EX/MEM 10, MEM/WB 01.
    function automatic exp_t exp_of(int m, int k);
        exp_t e;
        e.stalls = 0; e.a = RF; e.b = RF; e.chk_a = 1'b1; e.req = 4 + m;
        case (k)
            0: case (m) // ALU at distance 1, operand A
                   0: e.stalls = 2;
                   1: e.a = EM;
                   2: begin e.stalls = 1; e.a = MW; end
                   default: e.a = EM;
               endcase
            1: case (m) // ALU at distance 2, operand B
                   0: e.stalls = 1;
                   1: e.stalls = 1;
                   default: e.b = MW;
               endcase
            3: begin // load at distance 1, operand B (R10)
                   e.req = 10;
                   case (m)
                       0: e.stalls = 2;
                       1: e.stalls = 2;
                       default: begin e.stalls = 1; e.b = MW; end
                   endcase
               end
            4: case (m) // load at distance 2, operand A
                   0: e.stalls = 1;
                   1: e.stalls = 1;
                   default: e.a = MW;
               endcase
            7: e.req = 2;                  // register 0 (R2)
            8: begin                       // same register written twice (R8)
                   e.req = 8;
                   case (m)
                       0: e.stalls = 2;
                       1: e.a = EM;
                       2: begin e.stalls = 1; e.a = MW; end
                       default: e.a = EM;
                   endcase
               end
            9: begin e.req = 9; e.chk_a = 1'b0; end  // unused source (R9)
            10: begin                      // both operands dependent (R11)
                   e.req = 11;
                   case (m)
                       0: e.stalls = 2;
                       1: e.stalls = 2;
                       2: begin e.stalls = 1; e.a = MW; end
                       default: begin e.a = EM; e.b = MW; end
                   endcase
               end
            default: e.req = 3;            // 2, 5, 6: no hazard (R3)
        endcase
        return e;
    endfunction

    function automatic slot_t mk(int rs1, int rs2, int rd, bit we, bit ld,
                                 bit u1, bit u2, bit cons);
        slot_t s;
        s.rs1 = 5'(rs1); s.rs2 = 5'(rs2); s.rd = 5'(rd);
        s.we = we; s.ld = ld; s.u1 = u1; s.u2 = u2; s.cons = cons;
        return s;
    endfunction

    task automatic put(slot_t s);
        prog[plen] = s;
        plen++;
    endtask

    task automatic drain();
        for (int i = 0; i < 5; i++) put('0);
    endtask

    // Build the instruction stream: producers, fillers, consumer, drain
    initial begin
        slot_t alu5, ld5, fil;
        plen = 0;
        for (int i = 0; i < PLEN; i++) prog[i] = '0;
        alu5 = mk(0, 0, 5, 1, 0, 0, 0, 0);
        ld5  = mk(0, 0, 5, 1, 1, 0, 0, 0);
        fil  = mk(0, 0, 20, 1, 0, 0, 0, 0);
        put(alu5); put(mk(5, 0, 0, 0, 0, 1, 0, 1)); drain();              // 0
        put(alu5); put(fil); put(mk(0, 5, 0, 0, 0, 0, 1, 1)); drain();    // 1
        put(alu5); put(fil); put(fil); put(mk(5, 0, 0, 0, 0, 1, 0, 1)); drain(); // 2
        put(ld5); put(mk(0, 5, 0, 0, 0, 0, 1, 1)); drain();               // 3
        put(ld5); put(fil); put(mk(5, 0, 0, 0, 0, 1, 0, 1)); drain();     // 4
        put(ld5); put(fil); put(fil); put(mk(0, 5, 0, 0, 0, 0, 1, 1)); drain(); // 5
        put(alu5); put(mk(7, 0, 0, 0, 0, 1, 0, 1)); drain();              // 6
        put(mk(0, 0, 0, 1, 0, 0, 0, 0)); put(mk(0, 0, 0, 0, 0, 1, 0, 1)); drain(); // 7
        put(alu5); put(alu5); put(mk(5, 0, 0, 0, 0, 1, 0, 1)); drain();   // 8
        put(alu5); put(mk(5, 0, 0, 0, 0, 0, 0, 1)); drain();              // 9
        put(mk(0, 0, 6, 1, 0, 0, 0, 0)); put(alu5);
        put(mk(5, 6, 0, 0, 0, 1, 1, 1)); drain();                         // 10
    end

    for (genvar m = 0; m < 4; m++) begin : g_mode
        slot_t      ifid, idex, exmem, memwb;
        int         pc;
        logic [1:0] fa, fb;
        logic       ph, ih, ib;
        exp_t       q [$];
        int         nchk = 0, nbad = 0, ndone = 0, stall_cnt = 0;
        bit         rst_seen = 1'b0;

        hzd_forward_unit #(.REG_W(5), .MODE(fwd_mode_e'(m))) dut (
            .clk(clk), .rst_n(rst_n),
            .id_rs1(ifid.rs1), .id_rs2(ifid.rs2),
            .id_rs1_use(ifid.u1), .id_rs2_use(ifid.u2),
            .ex_rs1(idex.rs1), .ex_rs2(idex.rs2), .ex_rd(idex.rd),
            .ex_reg_we(idex.we), .ex_mem_rd(idex.ld),
            .mem_rd(exmem.rd), .mem_reg_we(exmem.we), .mem_mem_rd(exmem.ld),
            .wb_rd(memwb.rd), .wb_reg_we(memwb.we),
            .fwd_a(fa), .fwd_b(fb),
            .pc_hold(ph), .ifid_hold(ih), .idex_bubble(ib)
        );

        // Pipeline model steered only by the block's hold and bubble outputs
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ifid <= '0; idex <= '0; exmem <= '0; memwb <= '0; pc <= 0;
            end else begin
                memwb <= exmem;
                exmem <= idex;
                idex  <= ib ? '0 : ifid;
                if (!ih) ifid <= (pc < PLEN) ? prog[pc] : '0;
                if (!ph) pc <= pc + 1;
            end
        end

        // Driver: queue the expected result of every consumer
        initial begin
            for (int k = 0; k < NSC; k++) q.push_back(exp_of(m, k));
        end

        // Monitor: count stall cycles per consumer and compare on arrival
        always @(negedge clk) begin
            if (!rst_n) begin
                if (!rst_seen) begin
                    rst_seen = 1'b1;
                    nchk++;
                    if (ph || ih || ib || fa != RF || fb != RF) begin
                        nbad++;
                        $display("FAIL mode%0d R3 reset outputs actual=%b%b%b/%b/%b expected=000/00/00",
                                 m, ph, ih, ib, fa, fb);
                    end
                end
            end else begin
                nchk++;
                if (!(ph == ih && ih == ib)) begin
                    nbad++;
                    $display("FAIL mode%0d R9 hold/bubble actual=%b%b%b expected all equal",
                             m, ph, ih, ib);
                end
                if (ifid.cons && ph) stall_cnt++;
                if (idex.cons) begin
                    if (q.size() == 0) begin
                        nchk++; nbad++;
                        $display("FAIL mode%0d R3 extra consumer actual=%0d expected=%0d",
                                 m, ndone + 1, NSC);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        nchk++;
                        if (stall_cnt != e.stalls) begin
                            nbad++;
                            $display("FAIL mode%0d scen%0d R%0d stall cycles actual=%0d expected=%0d",
                                     m, ndone, e.req, stall_cnt, e.stalls);
                        end
                        if (e.chk_a) begin
                            nchk++;
                            if (fa !== e.a) begin
                                nbad++;
                                $display("FAIL mode%0d scen%0d R%0d R1 fwd_a actual=%b expected=%b",
                                         m, ndone, e.req, fa, e.a);
                            end
                        end
                        nchk++;
                        if (fb !== e.b) begin
                            nbad++;
                            $display("FAIL mode%0d scen%0d R%0d R1 fwd_b actual=%b expected=%b",
                                     m, ndone, e.req, fb, e.b);
                        end
                    end
                    stall_cnt = 0;
                    ndone++;
                end
            end
        end
    end

    // Reset, wait for all consumers under a watchdog, then summarise
    initial begin
        int total, bad, done;
        bit finished;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        finished = 1'b0;
        bad = 0;
        for (int cyc = 0; cyc < 2000 && !finished; cyc++) begin
            @(negedge clk);
            done = g_mode[0].ndone + g_mode[1].ndone + g_mode[2].ndone + g_mode[3].ndone;
            if (done >= 4 * NSC) finished = 1'b1;
        end
        repeat (4) @(negedge clk);
        total = g_mode[0].nchk + g_mode[1].nchk + g_mode[2].nchk + g_mode[3].nchk;
        bad   = g_mode[0].nbad + g_mode[1].nbad + g_mode[2].nbad + g_mode[3].nbad;
        total++;
        if (!finished) begin
            bad++;
            $display("FAIL watchdog R3 consumers seen actual=%0d expected=%0d", done, 4 * NSC);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule